// File: doc/BRIEF.md
# Host-to-PCI Address Bridge

This block sits between a CPU load/store bus and a simplified PCI transaction port. It decodes three CPU windows: a small control window that holds a local copy of the bridge's own 256-byte configuration header and three address registers, a 16 MiB memory window and a 256 KiB I/O window. Each window answers at two CPU addresses, which differ only in the top three address bits. Accesses to the memory and I/O windows are passed downstream. Their window offset is added to a base register that software sets, and their byte size is kept. Configuration cycles to other devices go indirectly: software loads a configuration-address register, then reads or writes a 32-bit data port in the control window.

The CPU side uses a request/ready handshake. The requester holds its request and attributes until `cpu_ready` pulses for one cycle. Local register accesses finish one cycle after acceptance. Forwarded accesses raise `dn_req` and hold it until the target answers with `dn_done`. The bridge serves one access at a time.

Top module: `hpb_bridge`

## Requirements
- R1: After reset `cpu_ready` and `dn_req` are low. Header word 0 reads {DEVICE_ID, VENDOR_ID} (default 0x0B521F0A). Header word 1 reads 0x02900080, which is bytes 0x80, 0x00, 0x90, 0x02 in little-endian order. The configuration-address register reads 0.
- R2: Control-window offsets 0x000 to 0x0FC (word aligned, 4-byte size, size code 2) read and write the 64 header words as full 32-bit values. Such an access gives `cpu_ready` at the first cycle after acceptance and never raises `dn_req`.
- R3: Offset 0x1C0 is the configuration-address register and reads back what was written. Offset 0x1C4 (memory base) and offset 0x1C8 (I/O base) take writes but read as 0. Every other control-window offset below 0x224 reads as 0.
- R4: A write to offset 0x220 forwards one configuration write (space code 0, size code 2) to the address held in the configuration-address register, carrying the write data. A read of offset 0x220 forwards a configuration read and returns `dn_rdata` on `cpu_rdata`.
- R5: A window offset below 16 MiB at CPU base 0x1D000000 or 0xFD000000 forwards to memory space (code 1). The address is offset + memory base modulo 2^32, and the size code is kept (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R6: A window offset below 256 KiB at CPU base 0x1E240000 or 0xFE240000 forwards to I/O space (code 2). The address is offset + I/O base modulo 2^32, and the size code is kept.
- R7: Some accesses are not serviced: a control-window access whose size code is not 2 or whose address is not word aligned, and a memory- or I/O-window access with size code 3. Each of these completes in one cycle, reads 0, changes no state and raises no `dn_req`.
- R8: The control window sits at 0x1E200000 and at 0xFE200000 and behaves the same at both. An address whose top three bits are neither 000 nor 111, or one that falls in no window, completes in one cycle with read data 0 and no `dn_req`.
- R9: Writes to unmapped control-window offsets are dropped. They change no register and raise no `dn_req`.
- R10: While `dn_req` is high and `dn_done` is low, every downstream field stays stable. In the cycle after `dn_done` is seen, `cpu_ready` is high and `dn_req` is low. `cpu_ready` and `dn_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = invalid |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| dn_req | output | 1 | Downstream transaction pending |
| dn_we | output | 1 | Downstream write flag |
| dn_space | output | 2 | 0 = configuration, 1 = memory, 2 = I/O |
| dn_size | output | 2 | Downstream size code |
| dn_addr | output | 32 | Translated downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_done | input | 1 | Target completion, one cycle |
| dn_rdata | input | 32 | Target read data, valid with `dn_done` |

## Verification
Two things can fall in the same cycle. A base-register or configuration-address update finishes, and in the very next accepted access the translation adder has to use the new value. The bench provokes this by writing a base register and issuing a window access straight after `cpu_ready`, with no idle cycles between them. It judges the result by the `dn_addr` that the responder captures, including a base that makes the sum wrap past 2^32. The other case is a target that raises `dn_done` in the first cycle of `dn_req`, where the data is captured in the same cycle the request closes. The bench checks the returned word and the two-cycle latency against a wait-state run.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int HDR_WORDS = 64;
  localparam int HDR_IDX_W = $clog2(HDR_WORDS);
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  typedef enum logic [1:0] {SP_CFG = 2'd0, SP_MEM = 2'd1, SP_IO = 2'd2} space_e;

  typedef enum logic [2:0] {
    RS_NONE, RS_HDR, RS_CFGA, RS_MBASE, RS_IOBASE, RS_DATA
  } regsel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} seq_e;

  typedef struct packed {
    logic                 fwd;
    space_e               space;
    logic [31:0]          offset;
    regsel_e              rsel;
    logic [HDR_IDX_W-1:0] hidx;
  } dec_t;
endpackage

// File: rtl/hpb_decode.sv
module hpb_decode
  import hpb_pkg::*;
#(
  parameter logic [2:0]  ALIAS_A       = 3'b000,
  parameter logic [2:0]  ALIAS_B       = 3'b111,
  parameter logic [28:0] REG_BASE      = 29'h1E20_0000,
  parameter logic [28:0] IO_BASE       = 29'h1E24_0000,
  parameter logic [28:0] MEM_BASE      = 29'h1D00_0000,
  parameter int          REG_PAGE_LOG2 = 12,
  parameter int          IO_SPAN_LOG2  = 18,
  parameter int          MEM_SPAN_LOG2 = 24,
  parameter logic [11:0] REG_SPAN      = 12'h224,
  parameter logic [11:0] CFGA_OFS      = 12'h1C0,
  parameter logic [11:0] MBASE_OFS     = 12'h1C4,
  parameter logic [11:0] IOBASE_OFS    = 12'h1C8,
  parameter logic [11:0] DATA_OFS      = 12'h220
) (
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  output dec_t        dec
);
  localparam logic [28:0] MEM_MASK  = 29'((64'd1 << MEM_SPAN_LOG2) - 1);
  localparam logic [28:0] IO_MASK   = 29'((64'd1 << IO_SPAN_LOG2) - 1);
  localparam logic [11:0] HDR_LIMIT = 12'(HDR_WORDS * 4);

  logic        alias_ok, in_mem, in_io, in_reg, win_size_ok, reg_size_ok;
  logic [28:0] low;
  logic [11:0] roff;

  always_comb begin
    low         = req_addr[28:0];
    roff        = req_addr[11:0];
    alias_ok    = (req_addr[31:29] == ALIAS_A) || (req_addr[31:29] == ALIAS_B);
    in_mem      = alias_ok && ((low >> MEM_SPAN_LOG2) == (MEM_BASE >> MEM_SPAN_LOG2));
    in_io       = alias_ok && ((low >> IO_SPAN_LOG2) == (IO_BASE >> IO_SPAN_LOG2));
    in_reg      = alias_ok && ((low >> REG_PAGE_LOG2) == (REG_BASE >> REG_PAGE_LOG2))
                  && (roff < REG_SPAN);
    win_size_ok = (req_size != SZ_BAD);
    reg_size_ok = (req_size == SZ_WORD) && (roff[1:0] == 2'b00);

    dec = '0;
    if (in_mem && win_size_ok) begin
      dec.fwd    = 1'b1;
      dec.space  = SP_MEM;
      dec.offset = {3'b000, low & MEM_MASK};
    end else if (in_io && win_size_ok) begin
      dec.fwd    = 1'b1;
      dec.space  = SP_IO;
      dec.offset = {3'b000, low & IO_MASK};
    end else if (in_reg && reg_size_ok) begin
      if (roff < HDR_LIMIT) begin
        dec.rsel = RS_HDR;
        dec.hidx = roff[HDR_IDX_W+1:2];
      end else if (roff == CFGA_OFS) begin
        dec.rsel = RS_CFGA;
      end else if (roff == MBASE_OFS) begin
        dec.rsel = RS_MBASE;
      end else if (roff == IOBASE_OFS) begin
        dec.rsel = RS_IOBASE;
      end else if (roff == DATA_OFS) begin
        dec.rsel  = RS_DATA;
        dec.fwd   = 1'b1;
        dec.space = SP_CFG;
      end
    end
  end
endmodule

// File: rtl/hpb_hdr.sv
module hpb_hdr
  import hpb_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'h1F0A,
  parameter logic [15:0] DEVICE_ID    = 16'h0B52,
  parameter logic [31:0] WORD1_INIT   = 32'h0290_0080
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [HDR_IDX_W-1:0] wr_idx,
  input  logic [31:0]          wr_data,
  input  logic [HDR_IDX_W-1:0] rd_idx,
  output logic [31:0]          rd_data
);
  logic [31:0] word_q [HDR_WORDS];

  for (genvar w = 0; w < HDR_WORDS; w++) begin : g_word
    localparam logic [31:0] INIT = (w == 0) ? {DEVICE_ID, VENDOR_ID} :
                                   (w == 1) ? WORD1_INIT : 32'h0;
    logic en;
    assign en = wr_en && (wr_idx == HDR_IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[w] <= INIT;
      else if (en)  word_q[w] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/hpb_seq.sv
module hpb_seq
  import hpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic fwd,
  input  logic dn_done,
  output logic launch,
  output logic local_ack,
  output logic capture,
  output logic dn_req,
  output logic cpu_ready
);
  seq_e state_q, state_d;

  always_comb begin
    launch    = (state_q == ST_IDLE) && cpu_req && fwd;
    local_ack = (state_q == ST_IDLE) && cpu_req && !fwd;
    capture   = (state_q == ST_WAIT) && dn_done;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: if (launch) state_d = ST_WAIT;
               else if (local_ack) state_d = ST_RESP;
      ST_WAIT: if (capture) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign dn_req    = (state_q == ST_WAIT);
  assign cpu_ready = (state_q == ST_RESP);
endmodule

// File: rtl/hpb_bridge.sv
module hpb_bridge
  import hpb_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1F0A,
  parameter logic [15:0] DEVICE_ID = 16'h0B52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        dn_req,
  output logic        dn_we,
  output logic [1:0]  dn_space,
  output logic [1:0]  dn_size,
  output logic [31:0] dn_addr,
  output logic [31:0] dn_wdata,
  input  logic        dn_done,
  input  logic [31:0] dn_rdata
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dec_t dec;
  logic launch, local_ack, capture;

  hpb_decode u_dec (
    .req_addr (cpu_addr),
    .req_size (cpu_size),
    .dec      (dec)
  );

  hpb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_req   (cpu_req),
    .fwd       (dec.fwd),
    .dn_done   (dn_done),
    .launch    (launch),
    .local_ack (local_ack),
    .capture   (capture),
    .dn_req    (dn_req),
    .cpu_ready (cpu_ready)
  );

  logic        wr_local, hdr_we, cfga_en, mbase_en, iobase_en;
  logic [31:0] hdr_rd;

  assign wr_local  = local_ack && cpu_we;
  assign hdr_we    = wr_local && (dec.rsel == RS_HDR);
  assign cfga_en   = wr_local && (dec.rsel == RS_CFGA);
  assign mbase_en  = wr_local && (dec.rsel == RS_MBASE);
  assign iobase_en = wr_local && (dec.rsel == RS_IOBASE);

  hpb_hdr #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_hdr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (hdr_we),
    .wr_idx  (dec.hidx),
    .wr_data (cpu_wdata),
    .rd_idx  (dec.hidx),
    .rd_data (hdr_rd)
  );

  // address registers
  logic [31:0] cfga_q, mbase_q, iobase_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfga_q   <= '0;
      mbase_q  <= '0;
      iobase_q <= '0;
    end else if (!rst_sync_n) begin
      cfga_q   <= '0;
      mbase_q  <= '0;
      iobase_q <= '0;
    end else begin
      if (cfga_en)   cfga_q   <= cpu_wdata;
      if (mbase_en)  mbase_q  <= cpu_wdata;
      if (iobase_en) iobase_q <= cpu_wdata;
    end
  end

  // next-state for read data and downstream fields
  logic [31:0] local_val, rdata_d, xaddr;
  logic        rdata_en;
  logic [1:0]  xsize;

  always_comb begin
    unique case (dec.rsel)
      RS_HDR:  local_val = hdr_rd;
      RS_CFGA: local_val = cfga_q;
      default: local_val = '0;
    endcase
    rdata_en = local_ack || capture;
    rdata_d  = capture ? dn_rdata : (cpu_we ? 32'h0 : local_val);
    unique case (dec.space)
      SP_MEM:  xaddr = mbase_q + dec.offset;
      SP_IO:   xaddr = iobase_q + dec.offset;
      default: xaddr = cfga_q;
    endcase
    xsize = (dec.space == SP_CFG) ? SZ_WORD : cpu_size;
  end

  logic [31:0] rdata_q, dn_addr_q, dn_wdata_q;
  logic [1:0]  dn_space_q, dn_size_q;
  logic        dn_we_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q    <= '0;
      dn_addr_q  <= '0;
      dn_wdata_q <= '0;
      dn_space_q <= '0;
      dn_size_q  <= '0;
      dn_we_q    <= 1'b0;
    end else begin
      if (rdata_en) rdata_q <= rdata_d;
      if (launch) begin
        dn_addr_q  <= xaddr;
        dn_wdata_q <= cpu_wdata;
        dn_space_q <= dec.space;
        dn_size_q  <= xsize;
        dn_we_q    <= cpu_we;
      end
    end
  end

  assign cpu_rdata = rdata_q;
  assign dn_addr   = dn_addr_q;
  assign dn_wdata  = dn_wdata_q;
  assign dn_space  = dn_space_q;
  assign dn_size   = dn_size_q;
  assign dn_we     = dn_we_q;
endmodule

// File: rtl/hpb_bridge_chk.sv
module hpb_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_ready,
  input logic        dn_req,
  input logic        dn_done,
  input logic        dn_we,
  input logic [1:0]  dn_space,
  input logic [1:0]  dn_size,
  input logic [31:0] dn_addr,
  input logic [31:0] dn_wdata
);
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_done) |=> (dn_req && $stable(dn_addr) && $stable(dn_space)
      && $stable(dn_size) && $stable(dn_we) && $stable(dn_wdata))); // R10

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_done) |=> (cpu_ready && !dn_req)); // R10

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ready && dn_req)); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R2

  AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> $past(cpu_req)); // R2

  AST_CFG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_space == 2'd0) |-> (dn_size == 2'd2)); // R4

  AST_SPACE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_space != 2'd3 && dn_size != 2'd3)); // R6
endmodule

bind hpb_bridge hpb_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .dn_req    (dn_req),
  .dn_done   (dn_done),
  .dn_we     (dn_we),
  .dn_space  (dn_space),
  .dn_size   (dn_size),
  .dn_addr   (dn_addr),
  .dn_wdata  (dn_wdata)
);

// File: tb/hpb_bridge_bench.sv
`timescale 1ns/1ps
module hpb_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        dn_req, dn_we, dn_done;
  logic [1:0]  dn_space, dn_size;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;

  always #2 clk = ~clk;

  hpb_bridge u_hpb_bridge (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_space(dn_space), .dn_size(dn_size),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_done(dn_done), .dn_rdata(dn_rdata)
  );

  localparam logic [31:0] RW  = 32'h1E20_0000;
  localparam logic [31:0] RWH = 32'hFE20_0000;
  localparam logic [31:0] IOW = 32'h1E24_0000;
  localparam logic [31:0] MW  = 32'h1D00_0000;

  int n_run = 0, n_fail = 0;
  int n_dn = 0, resp_wait = 0;
  logic [31:0] resp_data = '0;
  logic        ds_we;
  logic [1:0]  ds_space, ds_size;
  logic [31:0] ds_addr, ds_wdata;

  // downstream target model
  initial begin
    int wcnt;
    wcnt = 0;
    dn_done = 1'b0;
    dn_rdata = '0;
    forever begin
      @(negedge clk);
      if (dn_done) begin
        dn_done = 1'b0;
      end else if (dn_req) begin
        if (wcnt < resp_wait) begin
          wcnt++;
        end else begin
          wcnt = 0;
          ds_we = dn_we; ds_space = dn_space; ds_size = dn_size;
          ds_addr = dn_addr; ds_wdata = dn_wdata;
          dn_rdata = resp_data;
          dn_done = 1'b1;
          n_dn++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 64);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] rd; int cyc;
    chk("R1 ready low", {31'b0, cpu_ready}, 32'h0);
    chk("R1 dn_req low", {31'b0, dn_req}, 32'h0);
    acc(0, 2, RW + 32'h000, 0, rd, cyc); chk("R1 id word", rd, 32'h0B52_1F0A);
    acc(0, 2, RW + 32'h004, 0, rd, cyc); chk("R1 word1", rd, 32'h0290_0080);
    acc(0, 2, RW + 32'h1C0, 0, rd, cyc); chk("R1 cfg addr", rd, 32'h0);
  endtask

  task automatic t_header;
    logic [31:0] rd; int cyc, n0;
    n0 = n_dn;
    acc(1, 2, RW + 32'h0FC, 32'hA5A5_1234, rd, cyc); chk("R2 write cycles", cyc, 1);
    acc(0, 2, RW + 32'h0FC, 0, rd, cyc);
    chk("R2 last word", rd, 32'hA5A5_1234);
    chk("R2 read cycles", cyc, 1);
    acc(1, 2, RW + 32'h040, 32'h0BAD_F00D, rd, cyc);
    acc(0, 2, RW + 32'h040, 0, rd, cyc); chk("R2 mid word", rd, 32'h0BAD_F00D);
    chk("R2 no downstream", n_dn - n0, 0);
  endtask

  task automatic t_regs;
    logic [31:0] rd; int cyc;
    acc(1, 2, RW + 32'h1C0, 32'h8000_0810, rd, cyc);
    acc(0, 2, RW + 32'h1C0, 0, rd, cyc); chk("R3 cfg addr readback", rd, 32'h8000_0810);
    acc(1, 2, RW + 32'h1C4, 32'h0000_1234, rd, cyc);
    acc(0, 2, RW + 32'h1C4, 0, rd, cyc); chk("R3 mem base reads 0", rd, 32'h0);
    acc(1, 2, RW + 32'h1C8, 32'h0000_5678, rd, cyc);
    acc(0, 2, RW + 32'h1C8, 0, rd, cyc); chk("R3 io base reads 0", rd, 32'h0);
    acc(0, 2, RW + 32'h100, 0, rd, cyc); chk("R3 gap 0x100", rd, 32'h0);
    acc(0, 2, RW + 32'h1CC, 0, rd, cyc); chk("R3 gap 0x1CC", rd, 32'h0);
  endtask

  task automatic t_cfg;
    logic [31:0] rd; int cyc, n0;
    acc(1, 2, RW + 32'h1C0, 32'h8000_1004, rd, cyc);
    n0 = n_dn;
    acc(1, 2, RW + 32'h220, 32'hDEAD_BEEF, rd, cyc);
    chk("R4 one write", n_dn - n0, 1);
    chk("R4 wr space", {30'b0, ds_space}, 32'h0);
    chk("R4 wr addr", ds_addr, 32'h8000_1004);
    chk("R4 wr size", {30'b0, ds_size}, 32'h2);
    chk("R4 wr data", ds_wdata, 32'hDEAD_BEEF);
    chk("R4 wr flag", {31'b0, ds_we}, 32'h1);
    resp_data = 32'h1357_9BDF;
    acc(0, 2, RW + 32'h220, 0, rd, cyc);
    chk("R4 rd data", rd, 32'h1357_9BDF);
    chk("R4 rd flag", {31'b0, ds_we}, 32'h0);
    chk("R4 zero-wait cycles", cyc, 2);
  endtask

  task automatic t_mem;
    logic [31:0] rd; int cyc;
    acc(1, 2, RWH + 32'h1C4, 32'h4000_0000, rd, cyc);
    acc(1, 0, MW + 32'h10, 32'h0000_00AB, rd, cyc);
    chk("R5 byte addr", ds_addr, 32'h4000_0010);
    chk("R5 byte space", {30'b0, ds_space}, 32'h1);
    chk("R5 byte size", {30'b0, ds_size}, 32'h0);
    chk("R5 byte data", ds_wdata, 32'h0000_00AB);
    resp_data = 32'h0000_BEEF;
    acc(0, 1, 32'hFDFF_FFFE, 0, rd, cyc);
    chk("R5 top addr", ds_addr, 32'h40FF_FFFE);
    chk("R5 half size", {30'b0, ds_size}, 32'h1);
    chk("R5 half data", rd, 32'h0000_BEEF);
    acc(1, 2, RW + 32'h1C4, 32'hFFFF_FF00, rd, cyc);
    acc(1, 2, MW + 32'h200, 32'h1, rd, cyc);
    chk("R5 wrap addr", ds_addr, 32'h0000_0100);
  endtask

  task automatic t_io;
    logic [31:0] rd; int cyc;
    acc(1, 2, RW + 32'h1C8, 32'h0000_1000, rd, cyc);
    acc(1, 1, IOW + 32'h8, 32'h0000_55AA, rd, cyc);
    chk("R6 io addr", ds_addr, 32'h0000_1008);
    chk("R6 io space", {30'b0, ds_space}, 32'h2);
    chk("R6 io size", {30'b0, ds_size}, 32'h1);
    acc(0, 2, 32'hFE27_FFFC, 0, rd, cyc);
    chk("R6 io top addr", ds_addr, 32'h0004_0FFC);
    chk("R6 io word size", {30'b0, ds_size}, 32'h2);
  endtask

  task automatic t_unserviced;
    logic [31:0] rd; int cyc, n0;
    n0 = n_dn;
    acc(0, 0, RW + 32'h004, 0, rd, cyc);
    chk("R7 byte reg read", rd, 32'h0); chk("R7 byte reg cycles", cyc, 1);
    acc(1, 1, RW + 32'h000, 32'hFFFF_FFFF, rd, cyc);
    acc(1, 0, RW + 32'h1C0, 32'h0000_0077, rd, cyc);
    acc(0, 2, RW + 32'h002, 0, rd, cyc); chk("R7 misaligned read", rd, 32'h0);
    acc(0, 2, RW + 32'h000, 0, rd, cyc); chk("R7 id unchanged", rd, 32'h0B52_1F0A);
    acc(0, 2, RW + 32'h1C0, 0, rd, cyc); chk("R7 cfg addr unchanged", rd, 32'h8000_1004);
    acc(1, 3, MW + 32'h4, 32'h1, rd, cyc); chk("R7 bad size cycles", cyc, 1);
    acc(0, 3, IOW + 32'h4, 0, rd, cyc); chk("R7 bad size io read", rd, 32'h0);
    chk("R7 no downstream", n_dn - n0, 0);
  endtask

  task automatic t_alias;
    logic [31:0] rd; int cyc, n0;
    n0 = n_dn;
    acc(0, 2, RWH + 32'h004, 0, rd, cyc); chk("R8 upper alias", rd, 32'h0290_0080);
    acc(0, 2, 32'h3D00_0000, 0, rd, cyc);
    chk("R8 bad prefix data", rd, 32'h0); chk("R8 bad prefix cycles", cyc, 1);
    acc(1, 2, 32'h1E30_0000, 32'h9, rd, cyc); chk("R8 hole cycles", cyc, 1);
    chk("R8 no downstream", n_dn - n0, 0);
  endtask

  task automatic t_unmapped_wr;
    logic [31:0] rd; int cyc, n0;
    n0 = n_dn;
    acc(1, 2, RW + 32'h1D0, 32'h1111_1111, rd, cyc);
    acc(1, 2, RW + 32'h224, 32'h2222_2222, rd, cyc);
    acc(1, 2, RW + 32'h21C, 32'h3333_3333, rd, cyc);
    chk("R9 no downstream", n_dn - n0, 0);
    acc(0, 2, RW + 32'h1C0, 0, rd, cyc); chk("R9 cfg addr kept", rd, 32'h8000_1004);
    acc(0, 2, RW + 32'h1D0, 0, rd, cyc); chk("R9 reads 0", rd, 32'h0);
  endtask

  task automatic t_wait;
    logic [31:0] rd; int cyc;
    resp_wait = 3;
    resp_data = 32'hCAFE_0042;
    acc(0, 2, RW + 32'h220, 0, rd, cyc);
    chk("R10 waited data", rd, 32'hCAFE_0042);
    chk("R10 waited cycles", cyc, 5);
    resp_wait = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'd2;
    cpu_addr = '0; cpu_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_header();
    t_regs();
    t_cfg();
    t_mem();
    t_io();
    t_unserviced();
    t_alias();
    t_unmapped_wr();
    t_wait();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule